// File: doc/BRIEF.md
# Reservation Station with Broadcast Wakeup

This block is the issue queue that sits between rename and a single execution port. Each dispatched instruction occupies one slot. A slot holds the instruction's reorder-buffer index, its opcode and two source operands. An operand either arrives with its value already known, or it arrives holding the tag of the instruction that will produce it. Each cycle a result bus can carry one tag with its value. Every slot compares that tag with its pending operands in parallel and latches the value on a match. As a result, one broadcast can wake several slots in the same cycle.

A slot may leave only when both of its operands are present. Among the slots that may leave, the one dispatched earliest is sent to the execution port, at one per cycle. The others stay and are picked on later cycles. An instruction that does not depend on a slow producer can therefore issue before older instructions that are still waiting.

A flush request removes every slot younger than a given reorder-buffer index. When no slot is free, dispatch is refused.

Top module: `reservation_station`

## Requirements
- R1: After reset the pool is empty: `issue_valid` is 0 and `disp_ready` is 1.
- R2: A slot issues only when both of its operands are present. A slot with a pending operand never drives `issue_valid`. A slot dispatched with both operands present issues in the first cycle after the dispatch edge, carrying its index, opcode and values.
- R3: A bus cycle with `bcast_valid`=1 makes every pending operand whose tag equals `bcast_tag` take `bcast_val` at the same clock edge. Every slot woken this way is eligible from the next cycle on.
- R4: Suppose an operand is dispatched as pending and its tag equals the tag broadcast in that same cycle. That operand is stored as present, holding the broadcast value.
- R5: At most one slot issues per cycle. Among eligible slots, the one dispatched earliest wins. Slots that lose remain eligible and issue on following cycles, in dispatch order.
- R6: A slot whose operands are all present issues ahead of older slots that are still waiting on a producer.
- R7: An issued slot is freed at the issuing edge and never issues a second time.
- R8: With all ENTRIES slots occupied, `disp_ready` is 0, and a dispatch attempt in that state is dropped. Once a slot drains, `disp_ready` returns to 1.
- R9: Age is measured as (index − `rob_head`) modulo 2^ROB_W. While `flush_valid`=1, every slot whose age is greater than the age of `flush_rob_idx` is removed and never issues. Slots at or below that age are kept. A dispatch presented in a flush cycle is dropped.
- R10: An operand that is already present ignores the bus, even when the bus tag equals the operand's stale tag field. A broadcast with a non-matching tag leaves pending operands pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_ready | output | 1 | A free slot exists |
| disp_rob_idx | input | ROB_W (5) | Reorder-buffer index of the dispatched instruction |
| disp_op | input | OP_W (4) | Opcode carried to the port |
| disp_src1_rdy | input | 1 | Operand 1 value is present |
| disp_src1_tag | input | TAG_W (5) | Producer tag for operand 1 |
| disp_src1_val | input | DATA_W (16) | Operand 1 value when present |
| disp_src2_rdy | input | 1 | Operand 2 value is present |
| disp_src2_tag | input | TAG_W (5) | Producer tag for operand 2 |
| disp_src2_val | input | DATA_W (16) | Operand 2 value when present |
| bcast_valid | input | 1 | Result bus carries a result |
| bcast_tag | input | TAG_W (5) | Result bus tag |
| bcast_val | input | DATA_W (16) | Result bus value |
| flush_valid | input | 1 | Remove slots younger than `flush_rob_idx` |
| flush_rob_idx | input | ROB_W (5) | Youngest index that survives the flush |
| rob_head | input | ROB_W (5) | Index of the oldest in-flight instruction |
| issue_valid | output | 1 | An instruction is sent to the port this cycle |
| issue_rob_idx | output | ROB_W (5) | Index of the issued instruction |
| issue_op | output | OP_W (4) | Opcode of the issued instruction |
| issue_src1_val | output | DATA_W (16) | Operand 1 value |
| issue_src2_val | output | DATA_W (16) | Operand 2 value |

## Verification
A dispatch or a broadcast is registered at clock edge N. Its result on the issue port is therefore combinational from the slot state and is due in the cycle that follows edge N. The one exception is a flush, which masks issue in its own cycle. A removal or an issue frees the slot at the edge, so `disp_ready` recovers one cycle later. The bench drives every input just after the falling edge and samples the outputs one time unit later, so each check observes exactly the cycle in which a result becomes due.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int unsigned TAG_W  = 5;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned ROB_W  = 5;
  parameter int unsigned OP_W   = 4;

  typedef struct packed {
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } rs_opnd_t;

  typedef struct packed {
    logic [ROB_W-1:0] rob;
    logic [OP_W-1:0]  op;
    rs_opnd_t         src1;
    rs_opnd_t         src2;
  } rs_ent_t;

  // capture a broadcast result into a pending operand on tag match
  function automatic rs_opnd_t opnd_snoop(rs_opnd_t o, logic bv,
                                          logic [TAG_W-1:0] bt,
                                          logic [DATA_W-1:0] bd);
    rs_opnd_t r;
    r = o;
    if (!o.rdy && bv && (o.tag == bt)) begin
      r.rdy = 1'b1;
      r.val = bd;
    end
    return r;
  endfunction

  // distance from the oldest in-flight index, modulo the index space
  function automatic logic [ROB_W-1:0] rob_age(logic [ROB_W-1:0] idx,
                                               logic [ROB_W-1:0] head);
    return idx - head;
  endfunction
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int unsigned ENTRIES = 4
) (
  input  logic [ENTRIES-1:0] vld_i,
  output logic [ENTRIES-1:0] free_oh_o,
  output logic               full_o
);
  // lowest-numbered free slot
  always_comb begin
    free_oh_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_oh_o    = '0;
        free_oh_o[i] = 1'b1;
      end
    end
  end

  assign full_o = &vld_i;
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
  parameter int unsigned ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] alloc_i,
  input  logic [ENTRIES-1:0] cand_i,
  output logic [ENTRIES-1:0] grant_o
);
  // older_q[a][b] = 1 when slot a was filled before slot b
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q, older_d;
  logic                            older_en;

  always_comb begin
    older_d  = older_q;
    older_en = |alloc_i;
    for (int k = 0; k < ENTRIES; k++) begin
      if (alloc_i[k]) begin
        for (int j = 0; j < ENTRIES; j++) begin
          older_d[k][j] = 1'b0;
          older_d[j][k] = (j != k);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        older_q <= '0;
    else if (older_en) older_q <= older_d;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < ENTRIES; j++)
        blocked = blocked | (cand_i[j] & older_q[j][i]);
      grant_o[i] = cand_i[i] & ~blocked;
    end
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  assert_grant_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand_i) |-> (|(grant_o & cand_i)));
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  rs_ent_t           alloc_ent_i,
  input  logic              issue_i,
  input  logic              kill_i,
  input  logic              bc_vld_i,
  input  logic [TAG_W-1:0]  bc_tag_i,
  input  logic [DATA_W-1:0] bc_val_i,
  output logic              vld_o,
  output logic              rdy_o,
  output logic [ROB_W-1:0]  rob_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] v1_o,
  output logic [DATA_W-1:0] v2_o
);
  logic    vld_q, vld_d, ent_en;
  rs_ent_t ent_q, ent_d;

  always_comb begin
    vld_d  = vld_q;
    ent_d  = ent_q;
    ent_en = 1'b0;
    if (alloc_i) begin
      vld_d      = 1'b1;
      ent_en     = 1'b1;
      ent_d      = alloc_ent_i;
      ent_d.src1 = opnd_snoop(alloc_ent_i.src1, bc_vld_i, bc_tag_i, bc_val_i);
      ent_d.src2 = opnd_snoop(alloc_ent_i.src2, bc_vld_i, bc_tag_i, bc_val_i);
    end else if (issue_i || kill_i) begin
      vld_d = 1'b0;
    end else if (vld_q) begin
      ent_en     = 1'b1;
      ent_d.src1 = opnd_snoop(ent_q.src1, bc_vld_i, bc_tag_i, bc_val_i);
      ent_d.src2 = opnd_snoop(ent_q.src2, bc_vld_i, bc_tag_i, bc_val_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_d;
  end

  assign vld_o = vld_q;
  assign rdy_o = vld_q & ent_q.src1.rdy & ent_q.src2.rdy;
  assign rob_o = ent_q.rob;
  assign op_o  = ent_q.op;
  assign v1_o  = ent_q.src1.val;
  assign v2_o  = ent_q.src2.val;

  assert_issue_needs_operands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> (vld_q && ent_q.src1.rdy && ent_q.src2.rdy));
  assert_wakeup_src1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !issue_i && !kill_i && !ent_q.src1.rdy && bc_vld_i &&
     bc_tag_i == ent_q.src1.tag) |=>
    (ent_q.src1.rdy && ent_q.src1.val == $past(bc_val_i)));
  assert_wakeup_src2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !issue_i && !kill_i && !ent_q.src2.rdy && bc_vld_i &&
     bc_tag_i == ent_q.src2.tag) |=>
    (ent_q.src2.rdy && ent_q.src2.val == $past(bc_val_i)));
  assert_dispatch_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !alloc_ent_i.src1.rdy && bc_vld_i && bc_tag_i == alloc_ent_i.src1.tag)
    |=> ent_q.src1.rdy);
  assert_ready_operand_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !issue_i && !kill_i && ent_q.src1.rdy) |=> $stable(ent_q.src1.val));
  assert_issue_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> !vld_q);
  assert_flush_kills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !vld_q);
endmodule

// File: rtl/reservation_station.sv
module reservation_station
  import rs_pkg::*;
#(
  parameter int unsigned ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [ROB_W-1:0]  disp_rob_idx,
  input  logic [OP_W-1:0]   disp_op,
  input  logic              disp_src1_rdy,
  input  logic [TAG_W-1:0]  disp_src1_tag,
  input  logic [DATA_W-1:0] disp_src1_val,
  input  logic              disp_src2_rdy,
  input  logic [TAG_W-1:0]  disp_src2_tag,
  input  logic [DATA_W-1:0] disp_src2_val,
  input  logic              bcast_valid,
  input  logic [TAG_W-1:0]  bcast_tag,
  input  logic [DATA_W-1:0] bcast_val,
  input  logic              flush_valid,
  input  logic [ROB_W-1:0]  flush_rob_idx,
  input  logic [ROB_W-1:0]  rob_head,
  output logic              issue_valid,
  output logic [ROB_W-1:0]  issue_rob_idx,
  output logic [OP_W-1:0]   issue_op,
  output logic [DATA_W-1:0] issue_src1_val,
  output logic [DATA_W-1:0] issue_src2_val
);
  localparam int unsigned SYNC_STAGES = 2;

  // asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[SYNC_STAGES-1];

  logic [ENTRIES-1:0] vld_vec, rdy_vec, kill_vec, cand_vec, grant_vec;
  logic [ENTRIES-1:0] free_oh, alloc_vec, clr_vec;
  logic [ROB_W-1:0]   rob_arr [ENTRIES];
  logic [OP_W-1:0]    op_arr  [ENTRIES];
  logic [DATA_W-1:0]  v1_arr  [ENTRIES];
  logic [DATA_W-1:0]  v2_arr  [ENTRIES];
  logic               pool_full, disp_fire;
  logic [ROB_W-1:0]   flush_age;
  rs_ent_t            disp_ent;

  always_comb begin
    disp_ent.rob       = disp_rob_idx;
    disp_ent.op        = disp_op;
    disp_ent.src1.rdy  = disp_src1_rdy;
    disp_ent.src1.tag  = disp_src1_tag;
    disp_ent.src1.val  = disp_src1_val;
    disp_ent.src2.rdy  = disp_src2_rdy;
    disp_ent.src2.tag  = disp_src2_tag;
    disp_ent.src2.val  = disp_src2_val;
  end

  rs_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .vld_i     (vld_vec),
    .free_oh_o (free_oh),
    .full_o    (pool_full)
  );

  assign disp_ready = ~pool_full;
  assign disp_fire  = disp_valid & disp_ready & ~flush_valid;
  assign alloc_vec  = free_oh & {ENTRIES{disp_fire}};
  assign flush_age  = rob_age(flush_rob_idx, rob_head);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    rs_entry u_ent (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .alloc_i     (alloc_vec[g]),
      .alloc_ent_i (disp_ent),
      .issue_i     (grant_vec[g]),
      .kill_i      (kill_vec[g]),
      .bc_vld_i    (bcast_valid),
      .bc_tag_i    (bcast_tag),
      .bc_val_i    (bcast_val),
      .vld_o       (vld_vec[g]),
      .rdy_o       (rdy_vec[g]),
      .rob_o       (rob_arr[g]),
      .op_o        (op_arr[g]),
      .v1_o        (v1_arr[g]),
      .v2_o        (v2_arr[g])
    );
    assign kill_vec[g] = flush_valid & vld_vec[g] &
                         (rob_age(rob_arr[g], rob_head) > flush_age);
  end

  assign cand_vec = rdy_vec & ~kill_vec;
  assign clr_vec  = grant_vec | kill_vec;

  rs_age_select #(.ENTRIES(ENTRIES)) u_sel (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .alloc_i (alloc_vec),
    .cand_i  (cand_vec),
    .grant_o (grant_vec)
  );

  always_comb begin
    issue_rob_idx  = '0;
    issue_op       = '0;
    issue_src1_val = '0;
    issue_src2_val = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant_vec[i]) begin
        issue_rob_idx  = issue_rob_idx  | rob_arr[i];
        issue_op       = issue_op       | op_arr[i];
        issue_src1_val = issue_src1_val | v1_arr[i];
        issue_src2_val = issue_src2_val | v2_arr[i];
      end
    end
  end
  assign issue_valid = |grant_vec;

  assert_alloc_count_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    disp_fire |=> ($countones(vld_vec) ==
                   $past($countones(vld_vec)) + 1 - $past($countones(clr_vec))));
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!disp_ready && clr_vec == '0) |=> (vld_vec == $past(vld_vec)));
  assert_flush_blocks_dispatch_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (flush_valid && clr_vec == '0) |=> (vld_vec == $past(vld_vec)));
endmodule

// File: tb/reservation_station_tb.sv
module reservation_station_tb;
  import rs_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_ENT      = 4;

  logic              clk;
  logic              rst_n;
  logic              disp_valid, disp_ready;
  logic [ROB_W-1:0]  disp_rob_idx;
  logic [OP_W-1:0]   disp_op;
  logic              disp_src1_rdy, disp_src2_rdy;
  logic [TAG_W-1:0]  disp_src1_tag, disp_src2_tag;
  logic [DATA_W-1:0] disp_src1_val, disp_src2_val;
  logic              bcast_valid;
  logic [TAG_W-1:0]  bcast_tag;
  logic [DATA_W-1:0] bcast_val;
  logic              flush_valid;
  logic [ROB_W-1:0]  flush_rob_idx, rob_head;
  logic              issue_valid;
  logic [ROB_W-1:0]  issue_rob_idx;
  logic [OP_W-1:0]   issue_op;
  logic [DATA_W-1:0] issue_src1_val, issue_src2_val;

  int checks = 0;
  int errors = 0;

  reservation_station #(.ENTRIES(N_ENT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_rob_idx(disp_rob_idx), .disp_op(disp_op),
    .disp_src1_rdy(disp_src1_rdy), .disp_src1_tag(disp_src1_tag), .disp_src1_val(disp_src1_val),
    .disp_src2_rdy(disp_src2_rdy), .disp_src2_tag(disp_src2_tag), .disp_src2_val(disp_src2_val),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_val(bcast_val),
    .flush_valid(flush_valid), .flush_rob_idx(flush_rob_idx), .rob_head(rob_head),
    .issue_valid(issue_valid), .issue_rob_idx(issue_rob_idx), .issue_op(issue_op),
    .issue_src1_val(issue_src1_val), .issue_src2_val(issue_src2_val)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_issue(string req, bit v, int rob, int a, int b);
    chk(req, "issue_valid", issue_valid, v);
    if (v) begin
      chk(req, "issue_rob_idx", issue_rob_idx, rob);
      chk(req, "issue_src1_val", issue_src1_val, a);
      chk(req, "issue_src2_val", issue_src2_val, b);
    end
  endtask

  task automatic drv_idle();
    disp_valid = 0; disp_rob_idx = '0; disp_op = '0;
    disp_src1_rdy = 0; disp_src1_tag = '0; disp_src1_val = '0;
    disp_src2_rdy = 0; disp_src2_tag = '0; disp_src2_val = '0;
    bcast_valid = 0; bcast_tag = '0; bcast_val = '0;
    flush_valid = 0; flush_rob_idx = '0;
  endtask

  // start a new cycle: inputs change just after the falling edge
  task automatic next_cycle();
    @(negedge clk);
    drv_idle();
  endtask

  task automatic set_disp(int rob, int op, bit r1, int t1, int v1, bit r2, int t2, int v2);
    disp_valid = 1; disp_rob_idx = ROB_W'(rob); disp_op = OP_W'(op);
    disp_src1_rdy = r1; disp_src1_tag = TAG_W'(t1); disp_src1_val = DATA_W'(v1);
    disp_src2_rdy = r2; disp_src2_tag = TAG_W'(t2); disp_src2_val = DATA_W'(v2);
  endtask

  task automatic set_bcast(int t, int v);
    bcast_valid = 1; bcast_tag = TAG_W'(t); bcast_val = DATA_W'(v);
  endtask

  task automatic t_reset_state();
    next_cycle(); #1;
    chk("R1", "disp_ready", disp_ready, 1);
    chk("R1", "issue_valid", issue_valid, 0);
  endtask

  task automatic t_ready_dispatch();
    next_cycle(); set_disp(1, 3, 1, 0, 'hA1, 1, 0, 'hB2); #1;
    chk_issue("R2", 0, 0, 0, 0);
    next_cycle(); #1;
    chk_issue("R2", 1, 1, 'hA1, 'hB2);
    chk("R2", "issue_op", issue_op, 3);
    next_cycle(); #1;
    chk_issue("R7", 0, 0, 0, 0);
  endtask

  task automatic t_shared_wakeup();
    next_cycle(); set_disp(2, 1, 0, 7, 0, 1, 0, 'h202);
    next_cycle(); set_disp(3, 1, 1, 0, 'h303, 0, 7, 0); #1;
    chk_issue("R2", 0, 0, 0, 0);
    next_cycle(); #1;
    chk_issue("R2", 0, 0, 0, 0);
    set_bcast(7, 'h55);
    next_cycle(); #1;
    chk_issue("R3", 1, 2, 'h55, 'h202);
    next_cycle(); #1;
    chk_issue("R5", 1, 3, 'h303, 'h55);
    next_cycle(); #1;
    chk_issue("R7", 0, 0, 0, 0);
  endtask

  task automatic t_present_ignores_bus();
    next_cycle(); set_disp(4, 2, 1, 9, 'h11, 0, 10, 0);
    next_cycle(); set_bcast(9, 'hEE); #1;
    chk_issue("R10", 0, 0, 0, 0);
    next_cycle(); #1;
    chk_issue("R10", 0, 0, 0, 0);
    set_bcast(10, 'h22);
    next_cycle(); #1;
    chk_issue("R10", 1, 4, 'h11, 'h22);
    next_cycle(); #1;
    chk_issue("R7", 0, 0, 0, 0);
  endtask

  task automatic t_dispatch_bypass();
    next_cycle(); set_disp(5, 2, 0, 12, 0, 1, 0, 'h505); set_bcast(12, 'h77);
    next_cycle(); #1;
    chk_issue("R4", 1, 5, 'h77, 'h505);
    next_cycle(); #1;
    chk_issue("R7", 0, 0, 0, 0);
  endtask

  task automatic t_younger_first();
    next_cycle(); set_disp(6, 4, 0, 20, 0, 0, 21, 0);
    next_cycle(); set_disp(7, 4, 1, 0, 'h70, 1, 0, 'h71);
    next_cycle(); #1;
    chk_issue("R6", 1, 7, 'h70, 'h71);
    set_bcast(20, 'h60);
    next_cycle(); #1;
    chk_issue("R2", 0, 0, 0, 0);
    set_bcast(21, 'h61);
    next_cycle(); #1;
    chk_issue("R6", 1, 6, 'h60, 'h61);
    next_cycle(); #1;
    chk_issue("R7", 0, 0, 0, 0);
  endtask

  task automatic t_full_pool();
    for (int k = 0; k < N_ENT; k++) begin
      next_cycle(); set_disp(8 + k, 5, 0, 25, 0, 1, 0, k);
    end
    next_cycle(); #1;
    chk("R8", "disp_ready full", disp_ready, 0);
    set_disp(12, 5, 1, 0, 'hC0, 1, 0, 'hC1);
    next_cycle(); #1;
    chk_issue("R8", 0, 0, 0, 0);
    chk("R8", "disp_ready still full", disp_ready, 0);
    set_bcast(25, 'h99);
    for (int k = 0; k < N_ENT; k++) begin
      next_cycle(); #1;
      chk_issue("R5", 1, 8 + k, 'h99, k);
    end
    next_cycle(); #1;
    chk_issue("R8", 0, 0, 0, 0);
    chk("R8", "disp_ready drained", disp_ready, 1);
  endtask

  task automatic t_flush_wrap();
    rob_head = ROB_W'(30);
    for (int k = 0; k < N_ENT; k++) begin
      next_cycle(); set_disp((30 + k) % 32, 6, 0, 3, 0, 1, 0, 'h100 + k);
    end
    next_cycle(); flush_valid = 1; flush_rob_idx = ROB_W'(31); #1;
    chk_issue("R9", 0, 0, 0, 0);
    next_cycle(); #1;
    chk("R9", "disp_ready after flush", disp_ready, 1);
    flush_valid = 1; flush_rob_idx = ROB_W'(31);
    set_disp(2, 6, 1, 0, 'hD0, 1, 0, 'hD1);
    next_cycle(); #1;
    chk_issue("R9", 0, 0, 0, 0);
    set_bcast(3, 'h33);
    next_cycle(); #1;
    chk_issue("R9", 1, 30, 'h33, 'h100);
    next_cycle(); #1;
    chk_issue("R9", 1, 31, 'h33, 'h101);
    next_cycle(); #1;
    chk_issue("R9", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rob_head = '0;
    drv_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset_state();
    t_ready_dispatch();
    t_shared_wakeup();
    t_present_ignores_bus();
    t_dispatch_bypass();
    t_younger_first();
    t_full_pool();
    t_flush_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule